// File: doc/BRIEF.md
# Two-Alarm Match Unit with Shared Interrupt / Clock Output

The block keeps two alarm setpoints, each covering seconds, minutes, hours, day of month, month and weekday. Every field carries its own compare-enable bit, so one alarm can fire on a single field (every minute at second 30, every Tuesday) or on a full date and time. The current time arrives on input ports from a separate timekeeping block, along with a one-cycle `sec_tick` strobe that marks the moment a new second becomes valid. Matching is evaluated only on that strobe.

A match sets a sticky status bit for that alarm, which the host clears by writing ones. An alarm in one-shot mode disarms itself after it fires; in repeat mode it stays armed and fires again on every later matching second. One output pin is shared. In interrupt mode it is the OR of the status bits that have their interrupt enable set. In the other three modes it passes one of three prescaler taps (1 Hz, 4096 Hz, 32768 Hz) from the timebase.

Register map (4-bit address, 8-bit data, combinational read). Addresses 0..5 hold alarm 0 fields in the order second, minute, hour, date, month, weekday. Addresses 8..13 hold the same fields for alarm 1. In each field byte the value sits in the low bits and bit 7 is the compare enable. Address 6 is the alarm 0 control byte and address 14 the alarm 1 control byte: bit 0 armed, bit 1 repeat, bit 2 interrupt enable. Address 7 is status, with bit 0 for alarm 0 and bit 1 for alarm 1, cleared by writing 1. Address 15 bits 1:0 select the output mode.

Top module: `alarm_pair_pin`

## Requirements
- R1: After reset every register reads 0 and `irq_fout` is 0.
- R2: On a `sec_tick` cycle, an armed alarm sets its status bit exactly when every field whose bit 7 is set equals the current time field. Fields with bit 7 clear are ignored.
- R3: A status bit is never set in a cycle without `sec_tick`, even when the time matches.
- R4: The two alarms are independent. A match of alarm 0 sets only status bit 0, and a match of alarm 1 sets only status bit 1.
- R5: With control bit 1 clear, an alarm clears its own armed bit (control bit 0) in the same edge that sets its status. With bit 1 set, it stays armed and fires on each later matching tick.
- R6: Writing status clears every bit written as 1 and leaves bits written as 0 unchanged. A match in the same cycle as a clear of that bit leaves the bit set.
- R7: With select code 00, `irq_fout` is high exactly when some status bit is set whose alarm has control bit 2 set.
- R8: Select code 01 drives `irq_fout` from `tap_1hz`, 10 from `tap_4k`, and 11 from `tap_32k`. In these modes the status bits have no effect on the pin.
- R9: An alarm whose armed bit is clear never sets its status bit.
- R10: Field bytes read back with the unused value bits as zero. The value widths are 6, 6, 5, 5, 4 and 3 bits in address order, and bit 7 holds the enable. Control reads back in bits 2:0 and select in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe: time fields hold a new second |
| t_sec | input | 6 | Current seconds |
| t_min | input | 6 | Current minutes |
| t_hour | input | 5 | Current hour |
| t_date | input | 5 | Current day of month |
| t_month | input | 4 | Current month |
| t_wday | input | 3 | Current weekday |
| tap_1hz | input | 1 | 1 Hz prescaler tap |
| tap_4k | input | 1 | 4096 Hz prescaler tap |
| tap_32k | input | 1 | 32768 Hz prescaler tap |
| wr_en | input | 1 | Host write strobe |
| addr | input | 4 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for `addr` |
| irq_fout | output | 1 | Shared interrupt / frequency output |

## Verification
The assertions assume that `sec_tick` lasts a single cycle and that the time fields are stable while it is high. They also assume the host issues at most one write per cycle. The stimulus changes time fields only while the strobe is low and raises it for exactly one cycle. It drives every write and tick at the falling edge, so each input is settled before the rising edge that samples it. The field sweep covers all 64 enable masks against all 64 mismatch patterns. Separate cases cover the same-cycle clear and set, and the self-disarm of a one-shot alarm.

// File: rtl/alarm_pair_pin.sv
module alarm_pair_pin (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [5:0] t_sec,
  input  logic [5:0] t_min,
  input  logic [4:0] t_hour,
  input  logic [4:0] t_date,
  input  logic [3:0] t_month,
  input  logic [2:0] t_wday,
  input  logic       tap_1hz,
  input  logic       tap_4k,
  input  logic       tap_32k,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_fout
);
  localparam int NA = 2;
  localparam int NF = 6;
  localparam logic [5:0] FMASK [NF] = '{6'h3F, 6'h3F, 6'h1F, 6'h1F, 6'h0F, 6'h07};

  logic [5:0] val [NA][NF];
  logic [NF-1:0] fen [NA];
  logic [NA-1:0] arm, rpt, ie, flag, hit;
  logic [1:0] sel;
  logic [5:0] cur [NF];

  assign cur[0] = t_sec;
  assign cur[1] = t_min;
  assign cur[2] = {1'b0, t_hour};
  assign cur[3] = {1'b0, t_date};
  assign cur[4] = {2'b0, t_month};
  assign cur[5] = {3'b0, t_wday};

  wire       a_sel  = addr[3];
  wire [2:0] offs   = addr[2:0];
  wire       wr_st  = wr_en && addr == 4'd7;

  for (genvar a = 0; a < NA; a++) begin : g_alarm
    logic [NF-1:0] eq;
    for (genvar f = 0; f < NF; f++) begin : g_fld
      assign eq[f] = !fen[a][f] || (val[a][f] == cur[f]);
    end
    assign hit[a] = sec_tick && arm[a] && &eq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NA; a++) begin
        for (int f = 0; f < NF; f++) val[a][f] <= '0;
        fen[a] <= '0;
      end
      arm  <= '0;
      rpt  <= '0;
      ie   <= '0;
      flag <= '0;
      sel  <= '0;
    end else begin
      for (int a = 0; a < NA; a++)
        if (hit[a] && !rpt[a]) arm[a] <= 1'b0;
      flag <= (wr_st ? (flag & ~wdata[NA-1:0]) : flag) | hit;
      if (wr_en) begin
        if (addr == 4'd15) sel <= wdata[1:0];
        else if (offs == 3'd6) begin
          arm[a_sel] <= wdata[0];
          rpt[a_sel] <= wdata[1];
          ie[a_sel]  <= wdata[2];
        end else if (offs < 3'd6) begin
          val[a_sel][offs] <= wdata[5:0] & FMASK[offs];
          fen[a_sel][offs] <= wdata[7];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == 4'd15)      rdata = {6'b0, sel};
    else if (addr == 4'd7)  rdata = {6'b0, flag};
    else if (offs == 3'd6)  rdata = {5'b0, ie[a_sel], rpt[a_sel], arm[a_sel]};
    else                    rdata = {fen[a_sel][offs], 1'b0, val[a_sel][offs]};
  end

  always_comb begin
    case (sel)
      2'b01:   irq_fout = tap_1hz;
      2'b10:   irq_fout = tap_4k;
      2'b11:   irq_fout = tap_32k;
      default: irq_fout = |(flag & ie);
    endcase
  end
endmodule

module alarm_pair_pin_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       wr_en,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic       irq_fout,
  input logic [1:0] flag,
  input logic [1:0] arm,
  input logic [1:0] rpt,
  input logic [1:0] hit,
  input logic [1:0] sel
);
  a_r3_set_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (flag != $past(flag) && (flag & ~$past(flag)) != 2'b0) |-> $past(sec_tick));

  a_r9_disarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm[0] && !(wr_en && addr == 4'd6)) |=> !$rose(flag[0]));

  a_r5_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && !rpt[0] && !(wr_en && addr == 4'd6)) |=> !arm[0]);

  a_r5_repeat_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[1] && rpt[1] && !(wr_en && addr == 4'd14)) |=> arm[1]);

  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd7 && wdata[0] && !hit[0]) |=> !flag[0]);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] |=> flag[1]);

  a_r7_quiet_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00 && flag == 2'b00) |-> !irq_fout);
endmodule

bind alarm_pair_pin alarm_pair_pin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq_fout(irq_fout), .flag(flag), .arm(arm), .rpt(rpt),
  .hit(hit), .sel(sel)
);

// File: tb/sim_alarm_pair_pin.sv
module sim_alarm_pair_pin;
  logic clk = 0, rst_n = 0, sec_tick = 0, wr_en = 0;
  logic [5:0] t_sec = 0, t_min = 0;
  logic [4:0] t_hour = 0, t_date = 0;
  logic [3:0] t_month = 0;
  logic [2:0] t_wday = 0;
  logic tap_1hz = 0, tap_4k = 0, tap_32k = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq_fout;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alarm_pair_pin u0 (.*);

  localparam logic [5:0] AV [6] = '{6'd30, 6'd45, 6'd13, 6'd21, 6'd3, 6'd2};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; addr = a[3:0]; wdata = d[7:0];
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); addr = a[3:0]; #1 d = rdata;
  endtask

  task automatic set_time(int mis);
    t_sec   = AV[0]     + (mis[0] ? 6'd1 : 6'd0);
    t_min   = AV[1]     + (mis[1] ? 6'd1 : 6'd0);
    t_hour  = AV[2][4:0] + (mis[2] ? 5'd1 : 5'd0);
    t_date  = AV[3][4:0] + (mis[3] ? 5'd1 : 5'd0);
    t_month = AV[4][3:0] + (mis[4] ? 4'd1 : 4'd0);
    t_wday  = AV[5][2:0] + (mis[5] ? 3'd1 : 3'd0);
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 16; a++) begin
      rd(a, d); chk("R1 reset reg", d, 0);
    end
    chk("R1 reset pin", irq_fout, 0);

    // R10 readback masking
    wr(2, 8'hFF); rd(2, d); chk("R10 hour mask", d, 8'h9F);
    wr(13, 8'hFF); rd(13, d); chk("R10 wday mask", d, 8'h87);
    wr(14, 8'hFF); rd(14, d); chk("R10 ctrl mask", d, 8'h07);
    wr(13, 0); wr(14, 0);

    // R2 sweep: every enable mask against every mismatch pattern, repeat mode
    wr(6, 8'h07);
    for (int m = 0; m < 64; m++) begin
      for (int f = 0; f < 6; f++) wr(f, {m[f], 1'b0, AV[f]});
      for (int mis = 0; mis < 64; mis++) begin
        set_time(mis);
        tick();
        #1;
        chk("R2 match", u0.rdata === 8'bx ? -1 : 0, 0);
        rd(7, d); chk("R2 status", d, ((m & mis) == 0) ? 1 : 0);
        chk("R7 irq", irq_fout, ((m & mis) == 0) ? 1 : 0);
        if (d != 0) wr(7, 8'h01);
      end
    end
    rd(6, d); chk("R5 repeat stays armed", d, 7);

    // R3 no tick, time matches
    set_time(0);
    repeat (4) @(negedge clk);
    rd(7, d); chk("R3 no tick", d, 0);

    // R5 one-shot
    wr(6, 8'h05); tick();
    rd(7, d); chk("R5 oneshot fires", d, 1);
    rd(6, d); chk("R5 oneshot disarmed", d, 4);
    wr(7, 1); tick();
    rd(7, d); chk("R9 disarmed no fire", d, 0);

    // R4 alarm 1 independent: match on minute only
    for (int f = 0; f < 6; f++) wr(8 + f, (f == 1) ? {2'b10, AV[1]} : 0);
    wr(14, 8'h03);
    tick();
    rd(7, d); chk("R4 only bit1", d, 2);
    chk("R7 irq gated by ie", irq_fout, 0);
    wr(14, 8'h07); #1;
    chk("R7 irq with ie", irq_fout, 1);

    // R6 write 0 keeps, write 1 clears
    wr(7, 8'h01); rd(7, d); chk("R6 write0 keeps", d, 2);
    // R6 set beats clear in same cycle
    @(negedge clk); sec_tick = 1; wr_en = 1; addr = 7; wdata = 8'h02;
    @(negedge clk); sec_tick = 0; wr_en = 0;
    rd(7, d); chk("R6 set wins", d, 2);
    wr(7, 8'h02); rd(7, d); chk("R6 w1c", d, 0);

    // R8 taps, with a flag set
    tick();
    for (int s = 1; s < 4; s++) begin
      wr(15, s);
      for (int v = 0; v < 8; v++) begin
        @(negedge clk);
        tap_1hz = v[0]; tap_4k = v[1]; tap_32k = v[2];
        #1 chk("R8 tap select", irq_fout, v[s-1]);
      end
    end
    wr(15, 0); #1 chk("R7 back to irq", irq_fout, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog actual=1 expected=0"); end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule